// File: doc/BRIEF.md
# Pipelined Serial ADC Conversion Master

This block drives one external successive-approximation converter over a chip-select, gated-clock serial link. An event names a channel, says whether it belongs to a simultaneous-sample pair, and carries a tag. Each event goes through three chip-select frames. In the first frame the block shifts out an 8-bit control word. In the second frame it raises a conversion pulse. In the third frame it reads back the 16-bit result.

Frames run back to back. Each frame serves three different events at once: it sends the control word of the newest event, pulses the conversion of the event before it, and reads the result of the oldest event. With a full pipeline, one result is produced per frame. The surrounding controller decides when events happen and writes the results to memory. This block turns a stream of events into link waveforms and tagged result words. The link clock period, the clocks per frame, the setup time from select to clock, the hold time from clock to deselect, and the gap between frames are all set through configuration inputs. These inputs may be changed only while the link is idle.

Top module: `conv_link_master`

## Requirements
- R1: While reset is asserted and after it is released with no event offered, `link_cs_n`=1, `link_sclk`=0, `link_mosi`=0, `link_cnv`=0, `res_valid`=0 and `evt_ready`=1.
- R2: The control word of an event is {chan[3:0], 4'hF} when `evt_simul`=1 and {chan[3:0], 4'hD} otherwise. It is sent MSB first on `link_mosi`, one bit per link clock, during the first 8 clocks of a frame. Each bit is held from the rising edge through the falling edge. Outside those clocks, or when the frame has no event in its control slot, `link_mosi` is 0.
- R3: An event's control word is sent in frame n. `link_cnv` is high for the whole low time of `link_cs_n` in frame n+1. Its result is read in frame n+2.
- R4: A frame lasts 2·max(div,1)·(setup+nck+hold+gap) system clocks. While any event is in flight or waiting, frames follow each other with no idle cycle. With div=1, setup=1, nck=8, hold=0 and gap=9, a steady stream yields one result every 36 system clocks (18 link clocks).
- R5: Each half period of the link clock lasts max(`cfg_div`,1) system clocks, so a setting of 0 behaves like 1 and a setting of 1 gives half the system rate. Within each period, the high half comes first.
- R6: `link_cs_n` is low for setup+nck+hold link clocks per frame and then high for gap link clocks. `link_sclk` stays low during setup and hold and never goes high while `link_cs_n` is high.
- R7: In dual-bit mode (`cfg_dual`=1, nck=8) both data lines are sampled in the last system clock of each high half. The result arrives MSB first, with odd bits on `link_miso[1]` and even bits on `link_miso[0]`.
- R8: In single-bit mode (`cfg_dual`=0, nck=16) only `link_miso[0]` is sampled, one result bit per clock, MSB first.
- R9: When an event is accepted while the link is idle, `link_cs_n` falls exactly LAUNCH_LAT (default 4) system clocks after the accepting edge.
- R10: Each read frame of a real event produces `res_valid` for exactly one cycle, starting the cycle after the frame's last system clock. It comes with the captured 16-bit word and the event's tag. Frames without an event in the read slot produce no result.
- R11: `evt_ready` is high exactly when the one-entry holding slot is empty. An event accepted during a frame enters the control slot of the next frame. An event accepted on a frame's last cycle, with the holding slot empty, enters that next frame directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | DIV_W | Link half-period in system clocks (0 acts as 1) |
| cfg_nck | input | CFG_W | Link clocks per frame while selected |
| cfg_setup | input | CFG_W | Link clocks from select to first clock |
| cfg_hold | input | CFG_W | Link clocks from last clock to deselect |
| cfg_gap | input | CFG_W | Link clocks of deselect between frames |
| cfg_dual | input | 1 | 1: two data lines, 0: one data line |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event can be taken this cycle |
| evt_chan | input | 4 | Converter channel |
| evt_simul | input | 1 | Event is part of a simultaneous pair |
| evt_id | input | ID_W | Tag returned with the result |
| link_cs_n | output | 1 | Active-low chip select |
| link_sclk | output | 1 | Gated link clock |
| link_mosi | output | 1 | Control word line |
| link_cnv | output | 1 | Conversion pulse |
| link_miso | input | 2 | Result lines (bit 1 odd bits, bit 0 even bits) |
| res_valid | output | 1 | Result strobe |
| res_data | output | 16 | Result word |
| res_id | output | ID_W | Tag of the result |

## Verification
The bench builds the block with its default parameters: 8-bit divider, 6-bit timing fields, 4-bit tags and a launch latency of 4. It then changes the runtime configuration between idle periods. The 6-bit timing fields allow a 16-clock single-bit frame with a 17-clock gap, as well as dual-bit frames with zero setup or zero hold. A divider of 0, 1 and 2 exercises the zero clamp and stretched half periods. Back-to-back bursts fill all three pipeline slots, and spaced events bring the engine back to idle and through the launch delay many times.

// File: rtl/cl_pkg.sv
// Shared types and helpers for the conversion link master.
// Assumes a 4-bit channel field placed in the upper nibble of the control word.
package cl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_FRAME  = 2'd2
    } cl_state_e;

    localparam int CL_CTL_W = 8;

    // Builds the control word from channel and simultaneous flag.
    function automatic logic [CL_CTL_W-1:0] cl_ctl_word(input logic [3:0] chan, input logic simul);
        return {chan, (simul ? 4'hF : 4'hD)};
    endfunction

endpackage

// File: rtl/cl_frame_timer.sv
// Frame timer: produces chip select, gated clock, sample strobe and frame end.
// Counts system clocks within a link half period and half periods within a frame.
// Assumes configuration is stable while active and cfg_nck is at least 1.
module cl_frame_timer #(
    parameter int DIV_W = 8,
    parameter int CFG_W = 6,
    parameter int HW    = CFG_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [CFG_W-1:0] cfg_setup,
    input  logic [CFG_W-1:0] cfg_nck,
    input  logic [CFG_W-1:0] cfg_hold,
    input  logic [CFG_W-1:0] cfg_gap,
    output logic             cs_n,
    output logic             sclk,
    output logic             in_clk,
    output logic [HW-1:0]    clk_idx,
    output logic             sample_stb,
    output logic             frame_last
);

    logic [DIV_W-1:0] scnt;
    logic [DIV_W-1:0] h_last;
    logic [HW-1:0]    hcnt;
    logic [HW-1:0]    a_end;
    logic [HW-1:0]    b_end;
    logic [HW-1:0]    c_end;
    logic [HW-1:0]    ht_last;
    logic             half_end;
    logic             in_cs;

    // Frame boundaries in half periods.
    always_comb begin
        h_last  = (cfg_div == '0) ? '0 : cfg_div - DIV_W'(1);
        a_end   = HW'(cfg_setup) << 1;
        b_end   = a_end + (HW'(cfg_nck) << 1);
        c_end   = b_end + (HW'(cfg_hold) << 1);
        ht_last = c_end + (HW'(cfg_gap) << 1) - HW'(1);
    end

    // Half-period and position counters; held at zero while inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            scnt <= '0;
            hcnt <= '0;
        end else if (half_end) begin
            scnt <= '0;
            hcnt <= (hcnt == ht_last) ? '0 : hcnt + HW'(1);
        end else begin
            scnt <= scnt + DIV_W'(1);
        end
    end

    // Output decode from the position counters.
    always_comb begin
        half_end   = (scnt == h_last);
        in_cs      = active && (hcnt < c_end);
        in_clk     = active && (hcnt >= a_end) && (hcnt < b_end);
        cs_n       = !in_cs;
        sclk       = in_clk && !hcnt[0];
        clk_idx    = (hcnt - a_end) >> 1;
        sample_stb = sclk && half_end;
        frame_last = active && half_end && (hcnt == ht_last);
    end

    // R6
    sclk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

endmodule

// File: rtl/cl_rx_shift.sv
// Result shifter: gathers the readback word from one or two data lines.
// Assumes the strobe falls in the last system clock of each high half period.
module cl_rx_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic              dual,
    input  logic [1:0]        miso,
    output logic [DATA_W-1:0] word
);

    // Shift MSB first; line 1 carries the odd bit of each pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (sample_stb) begin
            if (dual) begin
                word <= {word[DATA_W-3:0], miso[1], miso[0]};
            end else begin
                word <= {word[DATA_W-2:0], miso[0]};
            end
        end
    end

endmodule

// File: rtl/cl_pipe_ctrl.sv
// Pipeline controller: holds one waiting event and three in-flight slots
// (control, convert, read). It launches frames and emits tagged results.
// Assumes the frame timer wraps by itself while active is held.
module cl_pipe_ctrl
    import cl_pkg::*;
#(
    parameter int ID_W       = 4,
    parameter int DATA_W     = 16,
    parameter int LAUNCH_LAT = 4,
    parameter int HW         = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    output logic              evt_ready,
    input  logic [3:0]        evt_chan,
    input  logic              evt_simul,
    input  logic [ID_W-1:0]   evt_id,
    input  logic              frame_last,
    input  logic              in_clk,
    input  logic [HW-1:0]     clk_idx,
    input  logic              cs_n,
    input  logic [DATA_W-1:0] rx_word,
    output logic              active,
    output logic              mosi,
    output logic              cnv,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [ID_W-1:0]   res_id
);

    localparam int NSLOT = 3;
    localparam int LW    = (LAUNCH_LAT < 2) ? 1 : $clog2(LAUNCH_LAT);

    cl_state_e         state;
    logic [LW-1:0]     lcnt;
    logic              nxt_vld;
    logic [3:0]        nxt_chan;
    logic              nxt_simul;
    logic [ID_W-1:0]   nxt_id;
    logic [NSLOT-1:0]  sv;
    logic [3:0]        s_chan  [NSLOT];
    logic              s_simul [NSLOT];
    logic [ID_W-1:0]   s_id    [NSLOT];
    logic              accept;
    logic              launch_done;
    logic              shift_en;
    logic              go_on;
    logic [CL_CTL_W-1:0] ctl0;
    logic [2:0]        bit_sel;

    // Handshake and sequencing conditions.
    always_comb begin
        evt_ready   = !nxt_vld;
        accept      = evt_valid && evt_ready;
        launch_done = (state == ST_LAUNCH) && (lcnt == LW'(LAUNCH_LAT - 1));
        shift_en    = launch_done || ((state == ST_FRAME) && frame_last);
        go_on       = nxt_vld || accept || sv[0] || sv[1];
        active      = (state == ST_FRAME);
    end

    // Engine state: idle, launch delay, running frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            lcnt  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_LAUNCH;
                        lcnt  <= '0;
                    end
                end
                ST_LAUNCH: begin
                    if (launch_done) state <= ST_FRAME;
                    else             lcnt  <= lcnt + LW'(1);
                end
                ST_FRAME: begin
                    if (frame_last && !go_on) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // One-entry holding slot in front of the pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_vld   <= 1'b0;
            nxt_chan  <= '0;
            nxt_simul <= 1'b0;
            nxt_id    <= '0;
        end else if (shift_en) begin
            nxt_vld <= 1'b0;
        end else if (accept) begin
            nxt_vld   <= 1'b1;
            nxt_chan  <= evt_chan;
            nxt_simul <= evt_simul;
            nxt_id    <= evt_id;
        end
    end

    // Slot advance at each frame boundary; slot 0 takes the waiting or offered event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv <= '0;
            for (int i = 0; i < NSLOT; i++) begin
                s_chan[i]  <= '0;
                s_simul[i] <= 1'b0;
                s_id[i]    <= '0;
            end
        end else if (shift_en) begin
            for (int i = NSLOT - 1; i > 0; i--) begin
                sv[i]      <= sv[i-1];
                s_chan[i]  <= s_chan[i-1];
                s_simul[i] <= s_simul[i-1];
                s_id[i]    <= s_id[i-1];
            end
            sv[0]      <= nxt_vld || accept;
            s_chan[0]  <= nxt_vld ? nxt_chan  : evt_chan;
            s_simul[0] <= nxt_vld ? nxt_simul : evt_simul;
            s_id[0]    <= nxt_vld ? nxt_id    : evt_id;
        end
    end

    // Result capture at the end of each frame whose read slot is occupied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_id    <= '0;
        end else begin
            res_valid <= frame_last && sv[NSLOT-1];
            if (frame_last && sv[NSLOT-1]) begin
                res_data <= rx_word;
                res_id   <= s_id[NSLOT-1];
            end
        end
    end

    // Control word bit and conversion pulse for the current frame.
    always_comb begin
        ctl0    = cl_ctl_word(s_chan[0], s_simul[0]);
        bit_sel = ~clk_idx[2:0];
        mosi    = in_clk && sv[0] && (clk_idx < HW'(CL_CTL_W)) && ctl0[bit_sel];
        cnv     = !cs_n && sv[1];
    end

    // R2
    mosi_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mosi |-> !cs_n);

    // R3
    cnv_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv |-> !cs_n);

    // R10
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R9
    launch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LAUNCH) |-> cs_n);

endmodule

// File: rtl/conv_link_master.sv
// Top of the conversion link master: ties the frame timer, the pipeline
// controller and the result shifter together. Configuration must only
// change while the link is idle.
module conv_link_master #(
    parameter int DIV_W      = 8,
    parameter int CFG_W      = 6,
    parameter int ID_W       = 4,
    parameter int LAUNCH_LAT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [CFG_W-1:0] cfg_nck,
    input  logic [CFG_W-1:0] cfg_setup,
    input  logic [CFG_W-1:0] cfg_hold,
    input  logic [CFG_W-1:0] cfg_gap,
    input  logic             cfg_dual,
    input  logic             evt_valid,
    output logic             evt_ready,
    input  logic [3:0]       evt_chan,
    input  logic             evt_simul,
    input  logic [ID_W-1:0]  evt_id,
    output logic             link_cs_n,
    output logic             link_sclk,
    output logic             link_mosi,
    output logic             link_cnv,
    input  logic [1:0]       link_miso,
    output logic             res_valid,
    output logic [15:0]      res_data,
    output logic [ID_W-1:0]  res_id
);

    localparam int HW     = CFG_W + 3;
    localparam int DATA_W = 16;

    logic              active;
    logic              in_clk;
    logic [HW-1:0]     clk_idx;
    logic              sample_stb;
    logic              frame_last;
    logic [DATA_W-1:0] rx_word;

    cl_frame_timer #(.DIV_W(DIV_W), .CFG_W(CFG_W), .HW(HW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .cfg_div    (cfg_div),
        .cfg_setup  (cfg_setup),
        .cfg_nck    (cfg_nck),
        .cfg_hold   (cfg_hold),
        .cfg_gap    (cfg_gap),
        .cs_n       (link_cs_n),
        .sclk       (link_sclk),
        .in_clk     (in_clk),
        .clk_idx    (clk_idx),
        .sample_stb (sample_stb),
        .frame_last (frame_last)
    );

    cl_rx_shift #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .dual       (cfg_dual),
        .miso       (link_miso),
        .word       (rx_word)
    );

    cl_pipe_ctrl #(.ID_W(ID_W), .DATA_W(DATA_W), .LAUNCH_LAT(LAUNCH_LAT), .HW(HW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_valid  (evt_valid),
        .evt_ready  (evt_ready),
        .evt_chan   (evt_chan),
        .evt_simul  (evt_simul),
        .evt_id     (evt_id),
        .frame_last (frame_last),
        .in_clk     (in_clk),
        .clk_idx    (clk_idx),
        .cs_n       (link_cs_n),
        .rx_word    (rx_word),
        .active     (active),
        .mosi       (link_mosi),
        .cnv        (link_cnv),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .res_id     (res_id)
    );

endmodule

// File: tb/sim_conv_link_master.sv
// Bench: behavioural model of link timing and pipeline compared every clock,
// plus a converter model that decodes the control word and returns a word built from it.
module sim_conv_link_master;

    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_div = 8'd1;
    logic [5:0]  cfg_nck = 6'd8, cfg_setup = 6'd1, cfg_hold = 6'd0, cfg_gap = 6'd9;
    logic        cfg_dual = 1'b1;
    logic        evt_valid = 1'b0;
    logic        evt_ready;
    logic [3:0]  evt_chan = '0;
    logic        evt_simul = 1'b0;
    logic [3:0]  evt_id = '0;
    logic        link_cs_n, link_sclk, link_mosi, link_cnv;
    logic [1:0]  link_miso = 2'b00;
    logic        res_valid;
    logic [15:0] res_data;
    logic [3:0]  res_id;

    conv_link_master u0 (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_nck(cfg_nck),
        .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_gap(cfg_gap), .cfg_dual(cfg_dual),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_chan(evt_chan),
        .evt_simul(evt_simul), .evt_id(evt_id), .link_cs_n(link_cs_n),
        .link_sclk(link_sclk), .link_mosi(link_mosi), .link_cnv(link_cnv),
        .link_miso(link_miso), .res_valid(res_valid), .res_data(res_data), .res_id(res_id)
    );

    always #10 clk = ~clk;   // 50 MHz

    int errors = 0, checks = 0, cyc = 0, nres = 0, nsent = 0;
    bit chk_en = 0, done = 0;
    int rq[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] ctl_of(input int code);
        logic [3:0] ch;
        ch = 4'((code / 2) % 16);
        return {ch, ((code % 2) == 1) ? 4'hF : 4'hD};
    endfunction

    function automatic int half_len();
        return (cfg_div == 0) ? 1 : int'(cfg_div);
    endfunction

    // ---- reference model state ----
    int m_st = 0, m_lc = 0, m_pos = 0, m_nv = 0, m_nx = 0;
    int sv0 = 0, sv1 = 0, sv2 = 0, se0 = 0, se1 = 0, se2 = 0;
    int m_rv = 0, m_re = 0;

    always @(posedge clk) begin
        int acc, inc, fl, go, nv, nx, rvn;
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_lc = 0; m_pos = 0; m_nv = 0;
            sv0 = 0; sv1 = 0; sv2 = 0; m_rv = 0;
        end else begin
            acc = (evt_valid && m_nv == 0) ? 1 : 0;
            inc = int'(evt_id) * 32 + int'(evt_chan) * 2 + int'(evt_simul);
            fl  = 2 * half_len() * (int'(cfg_setup) + int'(cfg_nck) + int'(cfg_hold) + int'(cfg_gap));
            rvn = 0;
            case (m_st)
                0: if (acc != 0) begin m_nv = 1; m_nx = inc; m_st = 1; m_lc = 0; end
                1: begin
                    if (m_lc == LAT - 1) begin
                        sv2 = sv1; se2 = se1; sv1 = sv0; se1 = se0; sv0 = m_nv; se0 = m_nx;
                        m_nv = 0; m_st = 2; m_pos = 0;
                    end else m_lc++;
                end
                default: begin
                    if (m_pos == fl - 1) begin
                        if (sv2 != 0) begin rvn = 1; m_re = se2; end
                        go = (m_nv != 0 || acc != 0 || sv0 != 0 || sv1 != 0) ? 1 : 0;
                        nv = (m_nv != 0 || acc != 0) ? 1 : 0;
                        nx = (m_nv != 0) ? m_nx : inc;
                        sv2 = sv1; se2 = se1; sv1 = sv0; se1 = se0; sv0 = nv; se0 = nx;
                        m_nv = 0; m_pos = 0;
                        if (go == 0) m_st = 0;
                    end else begin
                        m_pos++;
                        if (acc != 0) begin m_nv = 1; m_nx = inc; end
                    end
                end
            endcase
            m_rv = rvn;
        end
    end

    // ---- per-cycle comparison ----
    always @(negedge clk) begin
        int h, half, a, b, c, k;
        logic e_cs, e_sclk, e_mosi, e_cnv, inclk;
        logic [7:0] cw;
        if (chk_en) begin
            e_cs = 1; e_sclk = 0; e_mosi = 0; e_cnv = 0;
            if (m_st == 2) begin
                h = half_len(); half = m_pos / h;
                a = 2 * int'(cfg_setup); b = a + 2 * int'(cfg_nck); c = b + 2 * int'(cfg_hold);
                e_cs  = (half < c) ? 1'b0 : 1'b1;
                inclk = (half >= a && half < b);
                e_sclk = inclk && (((half - a) % 2) == 0);
                k = (half - a) / 2;
                cw = ctl_of(se0);
                if (inclk && sv0 != 0 && k < 8) e_mosi = cw[7 - k];
                e_cnv = !e_cs && (sv1 != 0);
            end
            check(link_cs_n == e_cs, "R6 cs_n", link_cs_n, e_cs);
            check(link_sclk == e_sclk, "R5 sclk", link_sclk, e_sclk);
            check(link_mosi == e_mosi, "R2 mosi", link_mosi, e_mosi);
            check(link_cnv == e_cnv, "R3 cnv", link_cnv, e_cnv);
            check(evt_ready == (m_nv == 0), "R11 evt_ready", evt_ready, (m_nv == 0));
            check(res_valid == (m_rv != 0), "R10 res_valid", res_valid, m_rv);
            if (res_valid && m_rv != 0) begin
                cw = ctl_of(m_re);
                if (cfg_dual) check(res_data == {cw, cw ^ 8'h5A}, "R7 res_data", res_data, {cw, cw ^ 8'h5A});
                else          check(res_data == {cw, cw ^ 8'h5A}, "R8 res_data", res_data, {cw, cw ^ 8'h5A});
                check(int'(res_id) == m_re / 32, "R10 res_id", res_id, m_re / 32);
            end
            if (res_valid) begin nres++; rq.push_back(cyc); end
        end
    end

    // ---- converter model: decodes the control word, answers two frames later ----
    logic       p_cs = 1, p_sclk = 0;
    logic [7:0] c1 = 0, c2 = 0, rxc = 0;
    logic [15:0] dw = 0;
    int ak = 0;
    always @(negedge clk) begin
        if (p_cs && !link_cs_n) begin ak = 0; rxc = 0; dw = {c2, c2 ^ 8'h5A}; end
        if (!p_sclk && link_sclk) begin
            if (ak < 8) rxc = {rxc[6:0], link_mosi};
            if (cfg_dual) link_miso = (ak < 8) ? {dw[15 - 2 * ak], dw[14 - 2 * ak]} : 2'b00;
            else          link_miso = (ak < 16) ? {1'b0, dw[15 - ak]} : 2'b00;
            ak++;
        end
        if (!p_cs && link_cs_n) begin c2 = c1; c1 = rxc; end
        p_cs = link_cs_n; p_sclk = link_sclk;
    end

    task automatic send(input int ch, input int sim, input int id);
        evt_valid = 1; evt_chan = 4'(ch); evt_simul = sim[0]; evt_id = 4'(id);
        while (!evt_ready) @(negedge clk);
        @(negedge clk);
        evt_valid = 0;
        nsent++;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_st != 0 || m_nv != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_cfg(input int d, input int s, input int n, input int hd, input int g, input bit du);
        cfg_div = 8'(d); cfg_setup = 6'(s); cfg_nck = 6'(n); cfg_hold = 6'(hd); cfg_gap = 6'(g); cfg_dual = du;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int lat, t0;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check(link_cs_n && !link_sclk && !link_mosi && !link_cnv && !res_valid && evt_ready,
              "R1 reset outputs", {link_cs_n, link_sclk, link_mosi, link_cnv, res_valid, evt_ready}, 6'b100001);
        rst_n = 1;
        @(negedge clk);
        chk_en = 1;
        repeat (5) @(negedge clk);
        check(link_cs_n && !res_valid && evt_ready, "R1 idle after reset",
              {link_cs_n, res_valid, evt_ready}, 3'b101);

        // Phase 1: dual-bit, 18-clock frame; launch latency and full pipeline
        set_cfg(1, 1, 8, 0, 9, 1);
        send(3, 1, 1);
        lat = 0;
        while (link_cs_n) begin @(negedge clk); lat++; end
        check(lat == LAT, "R9 launch latency", lat, LAT);
        wait_idle();
        rq.delete();
        for (int i = 0; i < 6; i++) send(i * 5 % 16, i % 2, i + 2);
        wait_idle();
        check(rq.size() == 6, "R4 burst result count", rq.size(), 6);
        for (int i = 1; i < rq.size(); i++)
            check(rq[i] - rq[i-1] == 36, "R4 result spacing", rq[i] - rq[i-1], 36);

        // Phase 2: divider 2, zero setup, spaced arrivals
        set_cfg(2, 0, 8, 1, 3, 1);
        for (int i = 0; i < 8; i++) begin
            send(15 - i, (i / 2) % 2, 8 + i);
            repeat ((i * 13) % 50) @(negedge clk);
        end
        wait_idle();

        // Phase 3: single-bit mode, 16 clocks, 17-clock gap
        set_cfg(1, 1, 16, 0, 17, 0);
        for (int i = 0; i < 4; i++) send(i + 9, 1 - (i % 2), i);
        repeat (40) @(negedge clk);
        send(6, 0, 12);
        wait_idle();

        // Phase 4: divider 0 acts as 1, hold and setup of 2
        set_cfg(0, 2, 8, 2, 2, 1);
        t0 = nres;
        for (int i = 0; i < 3; i++) send(i + 1, 1, 13 + i);
        wait_idle();
        check(nres - t0 == 3, "R10 results in div0 burst", nres - t0, 3);

        check(nres == nsent, "R10 one result per event", nres, nsent);
        finish_run();
    end

endmodule